// File: doc/BRIEF.md
# Two-Tier Countdown Timer Bank

A bank of saturating countdown timers advanced by a single tick strobe, usually pulsed once per video frame. An internal prescaler counts ticks and splits the bank into two groups. The fast group, on the low indices, steps on every tick. The slow group, on the high indices, steps only on the tick where the prescaler wraps, so it runs at 1/PERIOD of the tick rate.

Software or surrounding logic loads any timer through its own write strobe and data slice, reads every count in parallel, and watches a per-timer zero flag to learn when a delay has expired. A timer that reaches zero stays there until it is reloaded.

The timer width, the sizes of both groups and the prescaler period are parameters. The default period is 11 ticks.

Top module: `tt_timer_bank`

## Requirements
- R1: After reset every count reads 0 and every zero flag is 1. The prescaler starts so that the first slow-group step happens on the PERIOD-th tick after reset.
- R2: A fast-group timer (index below N_SHORT) decreases by exactly one on every tick while its count is nonzero.
- R3: A slow-group timer (index N_SHORT and above) decreases by one only on ticks number PERIOD, 2*PERIOD, 3*PERIOD, and so on, counted from reset. On all other ticks it holds.
- R4: A timer whose count is 0 stays at 0 on a tick and never wraps to the all-ones value.
- R5: When wr_en_i[i] is high at a clock edge, timer i loads wr_data_i[i*WIDTH +: WIDTH] at that edge. This holds even if tick_i is high, and no other timer is affected.
- R6: With tick_i low and no write strobe, every count holds its value.
- R7: zero_o[i] is 1 exactly when cnt_o[i*WIDTH +: WIDTH] is 0.
- R8: The prescaler counts every tick, whatever writes occur, so loading timers never shifts the slow-group step phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance strobe, one cycle per tick |
| wr_en_i | input | N_SHORT+N_LONG | Per-timer load strobe |
| wr_data_i | input | (N_SHORT+N_LONG)*WIDTH | Load values; timer i uses bits i*WIDTH +: WIDTH |
| cnt_o | output | (N_SHORT+N_LONG)*WIDTH | Current counts, same packing as wr_data_i |
| zero_o | output | N_SHORT+N_LONG | Per-timer expired flag |

## Verification
The bench uses a reduced configuration: two fast timers, two slow timers and a period of 5. It loads every timer with a sweep of starting values, including 0, 1, small counts and values near the top of the range, then ticks well past two prescaler periods. This separates the per-tick decrement of the fast group from the once-per-period step of the slow group, and it exposes any wrap below zero. Collisions of writes with ticks on chosen timers show that a load overrides the decrement only where it is strobed. A run that writes on every tick shows that the slow-group phase does not move. Idle stretches without ticks confirm that counts hold.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_DEF_PERIOD = 11;

  function automatic int unsigned tt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned PERIOD = tt_pkg::TT_DEF_PERIOD
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  localparam int unsigned PW = tt_pkg::tt_bits(PERIOD);
  localparam logic [PW-1:0] RELOAD = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;

  // wrap fires on the tick that would take the counter below zero
  assign wrap_o = tick_i && (phase_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RELOAD;
    end else if (tick_i) begin
      phase_q <= (phase_q == '0) ? RELOAD : phase_q - PW'(1);
    end
  end
endmodule

// File: rtl/tt_timer_cell.sv
module tt_timer_cell #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wr_data_i;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - WIDTH'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tt_timer_bank.sv
module tt_timer_bank #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned N_SHORT = 4,
  parameter int unsigned N_LONG  = 4,
  parameter int unsigned PERIOD  = tt_pkg::TT_DEF_PERIOD
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                tick_i,
  input  logic [N_SHORT+N_LONG-1:0]           wr_en_i,
  input  logic [(N_SHORT+N_LONG)*WIDTH-1:0]   wr_data_i,
  output logic [(N_SHORT+N_LONG)*WIDTH-1:0]   cnt_o,
  output logic [N_SHORT+N_LONG-1:0]           zero_o
);
  localparam int unsigned N_ALL = N_SHORT + N_LONG;

  logic long_step;

  tt_prescaler #(.PERIOD(PERIOD)) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wrap_o (long_step)
  );

  for (genvar i = 0; i < N_ALL; i++) begin : g_timer
    logic step;
    if (i < N_SHORT) begin : g_fast
      assign step = tick_i;
    end else begin : g_slow
      assign step = long_step;
    end

    tt_timer_cell #(.WIDTH(WIDTH)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step),
      .wr_i      (wr_en_i[i]),
      .wr_data_i (wr_data_i[i*WIDTH +: WIDTH]),
      .cnt_o     (cnt_o[i*WIDTH +: WIDTH]),
      .zero_o    (zero_o[i])
    );
  end
endmodule

// File: rtl/tt_timer_bank_chk.sv
module tt_timer_bank_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned N_SHORT = 4,
  parameter int unsigned N_LONG  = 4,
  parameter int unsigned PERIOD  = 11
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              tick_i,
  input logic [N_SHORT+N_LONG-1:0]         wr_en_i,
  input logic [(N_SHORT+N_LONG)*WIDTH-1:0] wr_data_i,
  input logic [(N_SHORT+N_LONG)*WIDTH-1:0] cnt_o,
  input logic                              long_step
);
  localparam int unsigned N_ALL = N_SHORT + N_LONG;
  localparam int unsigned CW    = tt_pkg::tt_bits(PERIOD + 1);

  // ticks seen since the last slow step
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (tick_i)    seen_q <= long_step ? '0 : seen_q + CW'(1);
  end

  assert_step_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_step |-> tick_i);

  assert_period_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && long_step) |-> (seen_q == CW'(PERIOD - 1)));

  assert_period_early_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !long_step) |-> (seen_q < CW'(PERIOD - 1)));

  for (genvar i = 0; i < N_ALL; i++) begin : g_chk
    assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[i] |=> (cnt_o[i*WIDTH +: WIDTH] == $past(wr_data_i[i*WIDTH +: WIDTH])));

    assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_en_i[i]) |=> $stable(cnt_o[i*WIDTH +: WIDTH]));

    assert_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[i] && cnt_o[i*WIDTH +: WIDTH] == '0) |=> (cnt_o[i*WIDTH +: WIDTH] == '0));

    if (i < N_SHORT) begin : g_fast
      assert_fast_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !wr_en_i[i] && cnt_o[i*WIDTH +: WIDTH] != '0) |=>
        (cnt_o[i*WIDTH +: WIDTH] == $past(cnt_o[i*WIDTH +: WIDTH]) - WIDTH'(1)));
    end else begin : g_slow
      assert_slow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!long_step && !wr_en_i[i]) |=> $stable(cnt_o[i*WIDTH +: WIDTH]));
    end
  end
endmodule

bind tt_timer_bank tt_timer_bank_chk #(
  .WIDTH(WIDTH), .N_SHORT(N_SHORT), .N_LONG(N_LONG), .PERIOD(PERIOD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .cnt_o     (cnt_o),
  .long_step (long_step)
);

// File: tb/tt_timer_bank_bench.sv
module tt_timer_bank_bench;
  localparam int W  = 8;
  localparam int NS = 2;
  localparam int NL = 2;
  localparam int N  = NS + NL;
  localparam int P  = 5;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic [N-1:0]   wr_en_i = '0;
  logic [N*W-1:0] wr_data_i = '0;
  logic [N*W-1:0] cnt_o;
  logic [N-1:0]   zero_o;

  always #2 clk_i = ~clk_i;

  tt_timer_bank #(.WIDTH(W), .N_SHORT(NS), .N_LONG(NL), .PERIOD(P)) u_tt_timer_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .zero_o(zero_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int mdl [N];
  int phase = P - 1;

  task automatic cmp(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // compare every timer and flag against the model
  task automatic check_all(input string ctx);
    for (int i = 0; i < N; i++) begin
      string tag;
      if (mdl[i] == 0)  tag = "R4";
      else if (i < NS)  tag = "R2";
      else              tag = "R3";
      cmp($sformatf("%s %s timer%0d", tag, ctx, i), int'(cnt_o[i*W +: W]), mdl[i]);
      cmp($sformatf("R7 %s flag%0d", ctx, i), int'(zero_o[i]), (mdl[i] == 0) ? 1 : 0);
    end
  endtask

  task automatic step(input logic tk, input logic [N-1:0] we, input logic [N*W-1:0] wd);
    bit wrap;
    @(negedge clk_i);
    tick_i = tk; wr_en_i = we; wr_data_i = wd;
    @(posedge clk_i);
    wrap = tk && (phase == 0);
    if (tk) phase = wrap ? P - 1 : phase - 1;
    for (int i = 0; i < N; i++) begin
      if (we[i])                                      mdl[i] = int'(wd[i*W +: W]);
      else if (tk && (i < NS || wrap) && mdl[i] != 0) mdl[i] = mdl[i] - 1;
    end
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = '0;
  endtask

  function automatic logic [N*W-1:0] fill(input int v);
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(v + i);
    return d;
  endfunction

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 released");

    // R1/R3: slow timers hold until the P-th tick after reset
    step(1'b0, '1, fill(20));
    for (int t = 1; t <= P + 1; t++) begin
      step(1'b1, '0, '0);
      check_all($sformatf("R1 phase tick%0d", t));
    end

    // R2/R3/R4: sweep of start values
    for (int v = 0; v < 16; v++) begin
      int sv = (v < 12) ? v : 240 + v;
      step(1'b0, '1, fill(sv));
      check_all($sformatf("R5 load %0d", sv));
      for (int t = 0; t < 2 * P + 3; t++) begin
        step(1'b1, '0, '0);
        check_all($sformatf("sweep v%0d t%0d", sv, t));
      end
    end

    // R5: write collides with tick on timers 0 and 2 only
    step(1'b0, '1, fill(50));
    for (int t = 0; t < 2 * P; t++) begin
      step(1'b1, 4'b0101, fill(100 + t));
      check_all($sformatf("R5 collide t%0d", t));
    end

    // R8: writes to fast timers on every tick keep the slow phase
    step(1'b0, '1, fill(9));
    for (int t = 0; t < 3 * P; t++) begin
      step(1'b1, 4'b0011, fill(t));
      check_all($sformatf("R8 phase t%0d", t));
    end

    // R6: idle cycles hold
    step(1'b0, '1, fill(77));
    for (int t = 0; t < 12; t++) begin
      step(1'b0, '0, '0);
      check_all($sformatf("R6 idle t%0d", t));
    end

    // R4: all-zero load then ticks, no wrap to all ones
    step(1'b0, '1, '0);
    for (int t = 0; t < P + 2; t++) begin
      step(1'b1, '0, '0);
      check_all($sformatf("R4 floor t%0d", t));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule